// File: doc/BRIEF.md
# Mixed-Decay Chopping Controller

This block sequences the H-bridge of each motor phase through charge, slow decay and fast decay so that the winding current stays at a setpoint. Time is kept in ticks of an external chopping oscillator. Four ticks make one chop period. A one-bit comparator per phase tells the block when the sensed current has reached its setpoint. A shared two-bit decay code sets how much of the end of each period is spent in fast decay. That code runs from none, through the last one or two ticks, to the whole period.

Every period opens with a short forced charge window. During that window the comparator is sampled again. A step pulse from the microstep sequencer restarts the period at once, so a new setpoint takes effect without waiting for the current period to finish. Charge can never run past the point where fast decay begins. This bounds the on-time when the setpoint is out of reach. Dropping the enable, or raising the fault input, turns all bridges off. It also clears the period timing.

Top module: `chop_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the clock after `enable` is low or `fault` is high, every phase reports off (00). Ticks, steps and comparator bits have no effect while disabled. The tick count restarts from zero when operation resumes.
- R2: The tick count advances on each `oscTick` pulse. The clock edge that sees the fourth tick after a period start begins a new period.
- R3: Fast decay starts at the tick index chosen by `decaySel`: 00 never, 01 at index 3, 10 at index 2, 11 at index 0. With code 11, charge ends only by the comparator.
- R4: Each period starts, including the first after enable, with a charge check lasting exactly CHECK_CYCLES clocks, whatever the comparator says.
- R5: When the check window ends, the next mode depends on the comparator samples taken during the window. If any was high, the phase goes to slow decay, or to fast decay once the fast point has been reached or with code 11. Otherwise it goes to charge, or to fast decay when past the fast point and the code is not 11.
- R6: In charge, a high comparator moves the phase to slow decay. It moves to fast decay instead with code 11 or once the fast point is reached.
- R7: With codes 01 and 10, charge never continues past the fast point.
- R8: Slow decay changes to fast decay at the fast point. Fast decay holds until the next period start.
- R9: A step pulse while enabled sets the tick count to zero. It starts a new period, showing charge on the next clock, from any mode. In the same cycle a step takes priority over a tick.
- R10: Phase i drives `bridgeMode[2i+1:2i]` with 00 off, 01 charge, 10 slow decay and 11 fast decay. Phases share the timing but follow their own comparators independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High to run; low forces all bridges off |
| fault | input | 1 | High forces all bridges off (e.g. overtemperature) |
| oscTick | input | 1 | One-clock pulse per chopping-oscillator cycle |
| stepPulse | input | 1 | One-clock pulse from the step sequencer |
| decaySel | input | 2 | Fast-decay tail select |
| atSetpoint | input | NUM_PHASES | Per-phase comparator, high when current has reached setpoint |
| bridgeMode | output | 2*NUM_PHASES | Per-phase bridge mode, two bits per phase |

## Verification
The bench targets the comparator pulse that arrives in the middle of the check window and is gone by its last clock. A design that sampled only at the end of the window would keep charging into a current that is already high. It also targets a setpoint that is never reached with codes 01 and 10: a missing on-time bound would leave the phase in charge for the whole period. With code 11 the zone starts at index zero. A design that treated that as a cut-off would never charge at all.

A step arriving together with a tick, or inside a running check window, is applied as well. A wrong priority would shift every later fast point by one tick, and a stale check counter would end the window early. Finally, the bench resumes after a fault that struck late in a period. A timer that kept its count would then enter fast decay too early.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
package chop_pkg;

  localparam int TICKS_PER_PERIOD = 4;
  localparam int TICK_W           = $clog2(TICKS_PER_PERIOD);

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_CHARGE = 2'b01,
    MODE_SLOW   = 2'b10,
    MODE_FAST   = 2'b11
  } bridge_mode_t;

  // commands from the period controller to the timer datapath
  typedef struct packed {
    logic clear;
    logic restart;
    logic advance;
  } timer_cmd_t;

  // shared timing strobes fanned out to every phase
  typedef struct packed {
    logic run;
    logic periodStart;
    logic checkEnd;
    logic fastZone;
    logic fullFast;
  } phase_strobe_t;

  // tick index at which fast decay begins; TICKS_PER_PERIOD means never
  function automatic logic [TICK_W:0] fastStartTick(input logic [1:0] sel);
    case (sel)
      2'b01:   return (TICK_W+1)'(TICKS_PER_PERIOD - 1);
      2'b10:   return (TICK_W+1)'(TICKS_PER_PERIOD - 2);
      2'b11:   return '0;
      default: return (TICK_W+1)'(TICKS_PER_PERIOD);
    endcase
  endfunction

endpackage

// File: rtl/chop_period_ctl.sv
`timescale 1ns/1ps
module chop_period_ctl
  import chop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       oscTick,
  input  logic       stepPulse,
  input  logic       lastTick,
  output timer_cmd_t cmd,
  output logic       periodStart
);

  logic runQ;
  logic startup;
  logic restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) runQ <= 1'b0;
    else        runQ <= run;
  end

  // first enabled clock, a step, or the wrap after the final tick
  assign startup = run & ~runQ;
  assign restart = run & (stepPulse | startup | (oscTick & lastTick));

  always_comb begin
    cmd.clear   = ~run;
    cmd.restart = restart;
    cmd.advance = run & oscTick & ~restart;
  end

  assign periodStart = restart;

endmodule

// File: rtl/chop_timer.sv
`timescale 1ns/1ps
module chop_timer
  import chop_pkg::*;
#(
  parameter int CHECK_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  timer_cmd_t cmd,
  input  logic [1:0] decaySel,
  output logic       lastTick,
  output logic       checkEnd,
  output logic       fastZone,
  output logic       fullFast
);

  localparam int CHK_W = $clog2(CHECK_CYCLES + 1);
  localparam logic [TICK_W-1:0] LAST_IDX = TICK_W'(TICKS_PER_PERIOD - 1);

  logic [TICK_W-1:0] tickCnt;
  logic [CHK_W-1:0]  checkCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tickCnt <= '0;
    end else if (cmd.clear || cmd.restart) begin
      tickCnt <= '0;
    end else if (cmd.advance) begin
      tickCnt <= (tickCnt == LAST_IDX) ? '0 : tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      checkCnt <= '0;
    end else if (cmd.clear) begin
      checkCnt <= '0;
    end else if (cmd.restart) begin
      checkCnt <= CHK_W'(CHECK_CYCLES);
    end else if (checkCnt != '0) begin
      checkCnt <= checkCnt - 1'b1;
    end
  end

  assign lastTick = (tickCnt == LAST_IDX);
  assign checkEnd = (checkCnt == CHK_W'(1));
  assign fastZone = ({1'b0, tickCnt} >= fastStartTick(decaySel));
  assign fullFast = (decaySel == 2'b11);

endmodule

// File: rtl/chop_phase_fsm.sv
`timescale 1ns/1ps
module chop_phase_fsm
  import chop_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  phase_strobe_t stb,
  input  logic          atSetpoint,
  output bridge_mode_t  mode
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_CHARGE,
    ST_SLOW,
    ST_FAST
  } phase_state_t;

  phase_state_t state;
  phase_state_t stateNext;
  logic         seenHigh;
  logic         aboveNow;

  assign aboveNow = seenHigh | atSetpoint;

  always_comb begin
    stateNext = state;
    if (!stb.run) begin
      stateNext = ST_IDLE;
    end else if (stb.periodStart) begin
      stateNext = ST_CHECK;
    end else begin
      case (state)
        ST_CHECK: begin
          if (stb.checkEnd) begin
            if (stb.fullFast)      stateNext = aboveNow ? ST_FAST : ST_CHARGE;
            else if (stb.fastZone) stateNext = ST_FAST;
            else                   stateNext = aboveNow ? ST_SLOW : ST_CHARGE;
          end
        end
        ST_CHARGE: begin
          if (atSetpoint)
            stateNext = (stb.fullFast || stb.fastZone) ? ST_FAST : ST_SLOW;
          else if (stb.fastZone && !stb.fullFast)
            stateNext = ST_FAST;
        end
        ST_SLOW: begin
          if (stb.fastZone) stateNext = ST_FAST;
        end
        ST_FAST: stateNext = ST_FAST;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  // comparator memory across the check window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            seenHigh <= 1'b0;
    else if (!stb.run || stb.periodStart)  seenHigh <= 1'b0;
    else if (state == ST_CHECK && atSetpoint) seenHigh <= 1'b1;
  end

  always_comb begin
    case (state)
      ST_CHECK, ST_CHARGE: mode = MODE_CHARGE;
      ST_SLOW:             mode = MODE_SLOW;
      ST_FAST:             mode = MODE_FAST;
      default:             mode = MODE_OFF;
    endcase
  end

endmodule

// File: rtl/chop_ctrl.sv
`timescale 1ns/1ps
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int NUM_PHASES   = 2,
  parameter int CHECK_CYCLES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    fault,
  input  logic                    oscTick,
  input  logic                    stepPulse,
  input  logic [1:0]              decaySel,
  input  logic [NUM_PHASES-1:0]   atSetpoint,
  output logic [2*NUM_PHASES-1:0] bridgeMode
);

  logic          run;
  logic          lastTick;
  logic          periodStart;
  logic          checkEnd;
  logic          fastZone;
  logic          fullFast;
  timer_cmd_t    timerCmd;
  phase_strobe_t phaseStb;
  bridge_mode_t  phaseMode [NUM_PHASES];

  assign run = enable & ~fault;

  chop_period_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .oscTick     (oscTick),
    .stepPulse   (stepPulse),
    .lastTick    (lastTick),
    .cmd         (timerCmd),
    .periodStart (periodStart)
  );

  chop_timer #(.CHECK_CYCLES(CHECK_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (timerCmd),
    .decaySel (decaySel),
    .lastTick (lastTick),
    .checkEnd (checkEnd),
    .fastZone (fastZone),
    .fullFast (fullFast)
  );

  always_comb begin
    phaseStb.run         = run;
    phaseStb.periodStart = periodStart;
    phaseStb.checkEnd    = checkEnd;
    phaseStb.fastZone    = fastZone;
    phaseStb.fullFast    = fullFast;
  end

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
    chop_phase_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .stb        (phaseStb),
      .atSetpoint (atSetpoint[g]),
      .mode       (phaseMode[g])
    );
    assign bridgeMode[2*g +: 2] = phaseMode[g];
  end

endmodule

// File: rtl/chop_ctrl_chk.sv
`timescale 1ns/1ps
module chop_ctrl_chk #(
  parameter int NUM_PHASES = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    enable,
  input logic                    fault,
  input logic                    stepPulse,
  input logic [1:0]              decaySel,
  input logic [2*NUM_PHASES-1:0] bridgeMode
);

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_chk
    logic [1:0] m;
    assign m = bridgeMode[2*g +: 2];

    // R1
    off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable || fault) |=> (m == 2'b00));

    // R4
    on_when_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !fault) |=> (m != 2'b00));

    // R9
    step_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !fault && stepPulse) |=> (m == 2'b01));

    // R8
    fast_not_to_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m == 2'b11) |=> (m != 2'b10));

    // R3
    no_fast_code0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (decaySel == 2'b00 && m != 2'b11) |=> (m != 2'b11));
  end

endmodule

bind chop_ctrl chop_ctrl_chk #(.NUM_PHASES(NUM_PHASES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .fault      (fault),
  .stepPulse  (stepPulse),
  .decaySel   (decaySel),
  .bridgeMode (bridgeMode)
);

// File: tb/chop_ctrl_bench.sv
`timescale 1ns/1ps
module chop_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       fault = 1'b0;
  logic       oscTick = 1'b0;
  logic       stepPulse = 1'b0;
  logic [1:0] decaySel = 2'b00;
  logic [1:0] atSetpoint = 2'b00;
  logic [3:0] bridgeMode;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  chop_ctrl #(.NUM_PHASES(2), .CHECK_CYCLES(3)) u_chop_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .fault      (fault),
    .oscTick    (oscTick),
    .stepPulse  (stepPulse),
    .decaySel   (decaySel),
    .atSetpoint (atSetpoint),
    .bridgeMode (bridgeMode)
  );

  // en, step, tick, {cmp1,cmp0}, decay, expected {mode1,mode0}, requirement
  // modes: 00 off, 01 charge, 10 slow, 11 fast (R10)
  typedef struct packed {
    logic       en;
    logic       step;
    logic       tick;
    logic [1:0] cmp;
    logic [1:0] dec;
    logic [3:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,2'b00,2'b01,4'b0101,4'd4},  //  0 R4 startup check
    '{1'b1,1'b0,1'b0,2'b10,2'b01,4'b0101,4'd4},  //  1 R4 mid-window pulse on phase 1
    '{1'b1,1'b0,1'b0,2'b00,2'b01,4'b0101,4'd4},  //  2 R4
    '{1'b1,1'b0,1'b0,2'b00,2'b01,4'b1001,4'd10}, //  3 R10 R5 ph1 slow, ph0 charge
    '{1'b1,1'b0,1'b1,2'b00,2'b01,4'b1001,4'd6},  //  4 R6 tick 1
    '{1'b1,1'b0,1'b1,2'b01,2'b01,4'b1010,4'd6},  //  5 R6 charge->slow, tick 2
    '{1'b1,1'b0,1'b1,2'b00,2'b01,4'b1010,4'd8},  //  6 R8 tick 3
    '{1'b1,1'b0,1'b0,2'b00,2'b01,4'b1111,4'd8},  //  7 R8 R3 fast at index 3
    '{1'b1,1'b0,1'b1,2'b00,2'b01,4'b0101,4'd2},  //  8 R2 fourth tick opens period
    '{1'b1,1'b0,1'b0,2'b00,2'b01,4'b0101,4'd4},  //  9 R4
    '{1'b1,1'b0,1'b0,2'b00,2'b01,4'b0101,4'd4},  // 10 R4
    '{1'b1,1'b0,1'b0,2'b10,2'b01,4'b1001,4'd5},  // 11 R5 last-clock sample
    '{1'b1,1'b0,1'b1,2'b00,2'b01,4'b1001,4'd7},  // 12 R7
    '{1'b1,1'b0,1'b1,2'b00,2'b01,4'b1001,4'd7},  // 13 R7
    '{1'b1,1'b0,1'b1,2'b00,2'b01,4'b1001,4'd7},  // 14 R7
    '{1'b1,1'b0,1'b0,2'b00,2'b01,4'b1111,4'd7},  // 15 R7 charge bounded
    '{1'b1,1'b1,1'b0,2'b00,2'b01,4'b0101,4'd9},  // 16 R9 step from fast
    '{1'b1,1'b0,1'b0,2'b00,2'b11,4'b0101,4'd4},  // 17 R4
    '{1'b1,1'b0,1'b0,2'b00,2'b11,4'b0101,4'd4},  // 18 R4
    '{1'b1,1'b0,1'b0,2'b10,2'b11,4'b1101,4'd5},  // 19 R5 code 11 above -> fast
    '{1'b1,1'b0,1'b1,2'b00,2'b11,4'b1101,4'd3},  // 20 R3 code 11 keeps charging
    '{1'b1,1'b0,1'b0,2'b01,2'b11,4'b1111,4'd6},  // 21 R6 charge->fast
    '{1'b1,1'b1,1'b1,2'b00,2'b11,4'b0101,4'd9},  // 22 R9 step with tick
    '{1'b1,1'b0,1'b1,2'b00,2'b11,4'b0101,4'd4},  // 23 R4
    '{1'b1,1'b1,1'b0,2'b00,2'b11,4'b0101,4'd9},  // 24 R9 step inside check
    '{1'b1,1'b0,1'b0,2'b00,2'b00,4'b0101,4'd4},  // 25 R4
    '{1'b1,1'b0,1'b0,2'b00,2'b00,4'b0101,4'd4},  // 26 R4 window restarted
    '{1'b1,1'b0,1'b0,2'b10,2'b00,4'b1001,4'd5},  // 27 R5
    '{1'b1,1'b0,1'b1,2'b00,2'b00,4'b1001,4'd3},  // 28 R3
    '{1'b1,1'b0,1'b1,2'b00,2'b00,4'b1001,4'd3},  // 29 R3
    '{1'b1,1'b0,1'b1,2'b00,2'b00,4'b1001,4'd3},  // 30 R3
    '{1'b1,1'b0,1'b0,2'b00,2'b00,4'b1001,4'd3},  // 31 R3 code 00 never fast
    '{1'b1,1'b1,1'b0,2'b01,2'b00,4'b0101,4'd9},  // 32 R9 step from charge
    '{1'b1,1'b0,1'b0,2'b00,2'b00,4'b0101,4'd4},  // 33 R4
    '{1'b1,1'b0,1'b0,2'b00,2'b00,4'b0101,4'd4},  // 34 R4
    '{1'b1,1'b0,1'b0,2'b00,2'b00,4'b0101,4'd5},  // 35 R5 no sample -> charge
    '{1'b1,1'b0,1'b1,2'b00,2'b10,4'b0101,4'd7},  // 36 R7
    '{1'b1,1'b0,1'b1,2'b00,2'b10,4'b0101,4'd7},  // 37 R7
    '{1'b1,1'b0,1'b0,2'b00,2'b10,4'b1111,4'd7},  // 38 R7 R3 fast at index 2
    '{1'b1,1'b0,1'b1,2'b00,2'b10,4'b1111,4'd8},  // 39 R8 fast holds
    '{1'b1,1'b0,1'b1,2'b00,2'b10,4'b0101,4'd2},  // 40 R2
    '{1'b1,1'b0,1'b1,2'b00,2'b10,4'b0101,4'd4},  // 41 R4
    '{1'b1,1'b0,1'b1,2'b00,2'b10,4'b0101,4'd4},  // 42 R4
    '{1'b1,1'b0,1'b0,2'b01,2'b10,4'b1111,4'd5}   // 43 R5 check ends in fast zone
  };

  task automatic drive(input logic en, input logic flt, input logic st, input logic tk,
                       input logic [1:0] cmp, input logic [1:0] dec);
    @(negedge clk);
    enable = en; fault = flt; stepPulse = st; oscTick = tk;
    atSetpoint = cmp; decaySel = dec;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic [3:0] exp, input string tag);
    checks++;
    if (bridgeMode !== exp) begin
      failures++;
      $display("FAIL %s: bridgeMode=%b expected=%b", tag, bridgeMode, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(4'b0000, "R1 off in reset");
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 2'b01);
    check(4'b0000, "R1 off while disabled after reset");

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].en, 1'b0, VECS[i].step, VECS[i].tick, VECS[i].cmp, VECS[i].dec);
      check(VECS[i].exp, $sformatf("R%0d row %0d", VECS[i].req, i));
    end

    // fault late in a period (tick index 2)
    drive(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 2'b10);
    check(4'b0000, "R1 fault forces off");
    drive(1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 2'b10);
    check(4'b0000, "R1 step and tick ignored under fault");
    drive(1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 2'b10);
    check(4'b0000, "R1 tick ignored under fault");
    drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b10);
    check(4'b0101, "R4 check after fault clears");
    drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b10);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b10);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b10);
    check(4'b0101, "R1 charge at index 0 after resume");
    drive(1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 2'b10);
    check(4'b0101, "R1 tick count restarted");
    drive(1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 2'b10);
    check(4'b0101, "R7 still before fast point");
    drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b10);
    check(4'b1111, "R7 fast at index 2 after resume");

    drive(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b10);
    check(4'b0000, "R1 enable low forces off");
    drive(1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 2'b10);
    check(4'b0000, "R1 inputs ignored while disabled");

    drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b10);
    check(4'b0101, "R4 check after enable");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(4'b0000, "R1 asynchronous reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule